// File: doc/BRIEF.md
# Bus Fault Capture and Replay Unit

This unit sits between a processor core's bus request port and the external memory bus. It supports instruction continuation. The core hands it one bus cycle at a time: address, function code, direction, size and write data. The unit drives that cycle onto the bus and holds it until the memory system either acknowledges it or aborts it with a bus-error input. When a cycle is aborted, the unit drops the cycle at once and freezes a record of it. The record holds the cycle's fields together with the program counter and status word that the core presents at that moment.

The record is visible as one packed frame image, so supervisor software can push it onto its stack. A frame image can also be written back, so that a record saved earlier can be restored before the return. A return-from-exception strobe makes the unit re-issue exactly the recorded cycle, with the same write data. While a replay is pending or running, a busy flag holds off new core requests. A done pulse marks a replay that completed, and after it normal sequencing goes on. A replay that is itself aborted counts as a fresh fault and replaces the record. One instruction may therefore fault, be replayed and fault again on its next cycle, several times over.

Top module: `bus_fault_replay`

## Requirements
- R1: After synchronous reset, bus_req_o, core_busy_o, core_ack_o, fault_o and replay_done_o are 0 and frame_o is all zero.
- R2: When idle and not busy, a core_req_i sampled at a clock edge starts a bus cycle. From the next cycle bus_req_o is 1 and the bus fields equal the request. They stay unchanged until bus_ack_i or bus_err_i is sampled. One cycle after bus_ack_i, core_ack_o pulses for one cycle with core_rdata_o equal to the sampled bus_rdata_i, and bus_req_o is 0.
- R3: A bus_err_i sampled during a cycle ends it. In the next cycle bus_req_o is 0, core_ack_o is 0 and fault_o pulses for one cycle. The record then holds valid=1, the cycle's address, fc, wr, size and wdata, and the core_pc_i and core_sr_i sampled at the error edge. bus_err_i takes precedence over bus_ack_i.
- R4: frame_o is the record packed from MSB to LSB as {valid, pc[31:0], sr[15:0], addr[31:0], fc[2:0], wr, size[1:0], wdata[31:0]}. It is 119 bits wide.
- R5: A frame_load_i sampled while idle and with no replay starting replaces the record with frame_i, using the R4 layout. A frame_load_i sampled during a bus cycle or a replay is ignored.
- R6: An rte_i sampled while idle with a valid record starts a replay. From the next cycle core_busy_o and bus_req_o are 1 and the bus fields equal the record. On bus_ack_i, the next cycle has replay_done_o and core_ack_o both pulsing, core_busy_o at 0 and the record valid bit cleared, with the other record fields unchanged.
- R7: An rte_i sampled while the record is not valid is ignored: no bus cycle starts and core_busy_o stays 0.
- R8: A bus_err_i during a replay is a new fault. It behaves as in R3, so the record is rewritten with the replayed fields and the current pc and sr. replay_done_o stays 0 and core_busy_o falls.
- R9: A core_req_i sampled while a cycle or replay is in progress, or while core_busy_o is 1, is ignored. The bus fields are unchanged and no cycle follows.
- R10: When rte_i (with a valid record) and core_req_i are sampled at the same idle edge, the replay wins and the core request is dropped.
- R11: A fetch fault, then a read fault, then a write fault, each followed by its replay, are each captured and replayed with their own fields.
- R12: An rte_i sampled during a core bus cycle makes core_busy_o 1 from the next cycle. After that cycle ends and the unit is idle for one cycle, the replay starts, provided the record is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_i | input | 1 | Core bus cycle request |
| core_addr_i | input | 32 | Core cycle logical address |
| core_fc_i | input | 3 | Core cycle function code |
| core_wr_i | input | 1 | Core cycle direction, 1 = write |
| core_size_i | input | 2 | Core cycle size code |
| core_wdata_i | input | 32 | Core cycle write data |
| core_pc_i | input | 32 | Program counter to record on a fault |
| core_sr_i | input | 16 | Status word to record on a fault |
| core_busy_o | output | 1 | Replay pending or in progress |
| core_ack_o | output | 1 | Cycle completed pulse |
| core_rdata_o | output | 32 | Read data of completed cycle |
| bus_req_o | output | 1 | Bus cycle active |
| bus_addr_o | output | 32 | Bus address |
| bus_fc_o | output | 3 | Bus function code |
| bus_wr_o | output | 1 | Bus direction |
| bus_size_o | output | 2 | Bus size code |
| bus_wdata_o | output | 32 | Bus write data |
| bus_ack_i | input | 1 | Bus cycle acknowledge |
| bus_err_i | input | 1 | Bus cycle abort |
| bus_rdata_i | input | 32 | Bus read data |
| rte_i | input | 1 | Return-from-exception strobe |
| frame_load_i | input | 1 | Write frame_i into the record |
| frame_i | input | 119 | Frame image to restore |
| frame_o | output | 119 | Current record as frame image |
| fault_o | output | 1 | Fault captured pulse |
| replay_done_o | output | 1 | Replay completed pulse |

## Verification
Directed sequences cover the cases that separate the unit's paths:
- an acknowledged read with wait states, which shows the cycle is held stable;
- an aborted write, which shows that capture includes the write data and the pc and sr;
- a replay that succeeds and one that faults again, which separates clearing the record from overwriting it;
- the fetch, read, write fault chain.

Collisions are also driven on purpose. These are rte with a core request, a core request or frame load during a replay, and rte during a core cycle. They show the priority and the pending path. A seeded random mix of cycle fields and outcomes, with frame save and restore, then checks that each recorded frame and each replayed cycle matches a model of the record.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
    parameter int unsigned ADDR_W = 32;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned PC_W   = 32;
    parameter int unsigned SR_W   = 16;
    parameter int unsigned FC_W   = 3;
    parameter int unsigned SIZE_W = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [FC_W-1:0]   fc;
        logic              wr;
        logic [SIZE_W-1:0] size;
        logic [DATA_W-1:0] wdata;
    } cyc_t;

    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] pc;
        logic [SR_W-1:0] sr;
        cyc_t            cyc;
    } rec_t;

    localparam int unsigned CYC_W   = $bits(cyc_t);
    localparam int unsigned FRAME_W = $bits(rec_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RPL  = 2'd2
    } st_t;

    function automatic logic [FRAME_W-1:0] rec_to_frame(rec_t r);
        return r;
    endfunction

    function automatic rec_t frame_to_rec(logic [FRAME_W-1:0] f);
        return rec_t'(f);
    endfunction

    function automatic cyc_t make_cyc(logic [ADDR_W-1:0] a, logic [FC_W-1:0] fc,
                                      logic wr, logic [SIZE_W-1:0] sz,
                                      logic [DATA_W-1:0] wd);
        cyc_t c;
        c.addr  = a;
        c.fc    = fc;
        c.wr    = wr;
        c.size  = sz;
        c.wdata = wd;
        return c;
    endfunction
endpackage

// File: rtl/bfr_seq.sv
module bfr_seq
    import bfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req_i,
    input  cyc_t              core_cyc_i,
    input  logic              rte_i,
    input  logic              rec_valid_i,
    input  cyc_t              rec_cyc_i,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              active_o,
    output cyc_t              cur_o,
    output logic              busy_o,
    output logic              cap_o,
    output logic              clr_o,
    output logic              ld_ok_o,
    output logic              core_ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              fault_o,
    output logic              done_o
);
    st_t               st_q, st_d;
    cyc_t              cur_q, cur_d;
    logic              pend_q, pend_d;
    logic              ack_q, ack_d, flt_q, flt_d, dn_q, dn_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              go, launch;

    assign go     = rte_i | pend_q;
    assign launch = (st_q == ST_IDLE) & go & rec_valid_i;

    always_comb begin
        st_d    = st_q;
        cur_d   = cur_q;
        pend_d  = pend_q;
        rdata_d = rdata_q;
        ack_d   = 1'b0;
        flt_d   = 1'b0;
        dn_d    = 1'b0;
        cap_o   = 1'b0;
        clr_o   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                pend_d = 1'b0;
                if (launch) begin
                    st_d  = ST_RPL;
                    cur_d = rec_cyc_i;
                end else if (core_req_i && !pend_q) begin
                    st_d  = ST_RUN;
                    cur_d = core_cyc_i;
                end
            end
            ST_RUN: begin
                if (rte_i) pend_d = 1'b1;
                if (bus_err_i) begin
                    cap_o = 1'b1;
                    flt_d = 1'b1;
                    st_d  = ST_IDLE;
                end else if (bus_ack_i) begin
                    ack_d   = 1'b1;
                    rdata_d = bus_rdata_i;
                    st_d    = ST_IDLE;
                end
            end
            ST_RPL: begin
                if (bus_err_i) begin
                    cap_o = 1'b1;
                    flt_d = 1'b1;
                    st_d  = ST_IDLE;
                end else if (bus_ack_i) begin
                    clr_o   = 1'b1;
                    ack_d   = 1'b1;
                    dn_d    = 1'b1;
                    rdata_d = bus_rdata_i;
                    st_d    = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cur_q   <= '0;
            pend_q  <= 1'b0;
            ack_q   <= 1'b0;
            flt_q   <= 1'b0;
            dn_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            cur_q   <= cur_d;
            pend_q  <= pend_d;
            ack_q   <= ack_d;
            flt_q   <= flt_d;
            dn_q    <= dn_d;
            rdata_q <= rdata_d;
        end
    end

    assign active_o   = (st_q != ST_IDLE);
    assign cur_o      = cur_q;
    assign busy_o     = pend_q | (st_q == ST_RPL);
    assign ld_ok_o    = (st_q == ST_IDLE) & ~launch;
    assign core_ack_o = ack_q;
    assign rdata_o    = rdata_q;
    assign fault_o    = flt_q;
    assign done_o     = dn_q;

    // R2 / R9: an open cycle keeps its fields until the bus answers
    p_hold_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && !bus_ack_i && !bus_err_i) |=> ($stable(cur_q) && st_q == $past(st_q)));

    // R3: an abort ends the cycle and raises only the fault pulse
    p_abort_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && bus_err_i) |=> (st_q == ST_IDLE && fault_o && !core_ack_o));

    // R2 / R3: completion and fault never reported together
    p_resp_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fault_o, core_ack_o}));

    // R6: a finished replay also completes the core's cycle
    p_done_ack_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> core_ack_o);
endmodule

// File: rtl/bfr_rec.sv
module bfr_rec
    import bfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_i,
    input  cyc_t               cyc_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [SR_W-1:0]    sr_i,
    input  logic               ld_i,
    input  logic               ld_ok_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               clr_i,
    output rec_t               rec_o
);
    rec_t rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (cap_i) begin
            rec_q.valid <= 1'b1;
            rec_q.pc    <= pc_i;
            rec_q.sr    <= sr_i;
            rec_q.cyc   <= cyc_i;
        end else if (ld_i && ld_ok_i) begin
            rec_q <= frame_to_rec(frame_i);
        end else if (clr_i) begin
            rec_q.valid <= 1'b0;
        end
    end

    assign rec_o = rec_q;

    // R3: a capture leaves a valid record of the faulted cycle
    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> (rec_q.valid && rec_q.cyc == $past(cyc_i) && rec_q.pc == $past(pc_i)));

    // R6: a successful replay retires the record but keeps its fields
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !cap_i) |=> (!rec_q.valid && $stable(rec_q.cyc)));
endmodule

// File: rtl/bus_fault_replay.sv
module bus_fault_replay
    import bfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               core_req_i,
    input  logic [ADDR_W-1:0]  core_addr_i,
    input  logic [FC_W-1:0]    core_fc_i,
    input  logic               core_wr_i,
    input  logic [SIZE_W-1:0]  core_size_i,
    input  logic [DATA_W-1:0]  core_wdata_i,
    input  logic [PC_W-1:0]    core_pc_i,
    input  logic [SR_W-1:0]    core_sr_i,
    output logic               core_busy_o,
    output logic               core_ack_o,
    output logic [DATA_W-1:0]  core_rdata_o,
    output logic               bus_req_o,
    output logic [ADDR_W-1:0]  bus_addr_o,
    output logic [FC_W-1:0]    bus_fc_o,
    output logic               bus_wr_o,
    output logic [SIZE_W-1:0]  bus_size_o,
    output logic [DATA_W-1:0]  bus_wdata_o,
    input  logic               bus_ack_i,
    input  logic               bus_err_i,
    input  logic [DATA_W-1:0]  bus_rdata_i,
    input  logic               rte_i,
    input  logic               frame_load_i,
    input  logic [FRAME_W-1:0] frame_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               fault_o,
    output logic               replay_done_o
);
    cyc_t core_cyc, cur;
    rec_t rec;
    logic active, cap, clr, ld_ok;

    assign core_cyc = make_cyc(core_addr_i, core_fc_i, core_wr_i, core_size_i, core_wdata_i);

    bfr_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .core_req_i  (core_req_i),
        .core_cyc_i  (core_cyc),
        .rte_i       (rte_i),
        .rec_valid_i (rec.valid),
        .rec_cyc_i   (rec.cyc),
        .bus_ack_i   (bus_ack_i),
        .bus_err_i   (bus_err_i),
        .bus_rdata_i (bus_rdata_i),
        .active_o    (active),
        .cur_o       (cur),
        .busy_o      (core_busy_o),
        .cap_o       (cap),
        .clr_o       (clr),
        .ld_ok_o     (ld_ok),
        .core_ack_o  (core_ack_o),
        .rdata_o     (core_rdata_o),
        .fault_o     (fault_o),
        .done_o      (replay_done_o)
    );

    bfr_rec u_rec (
        .clk     (clk),
        .rst     (rst),
        .cap_i   (cap),
        .cyc_i   (cur),
        .pc_i    (core_pc_i),
        .sr_i    (core_sr_i),
        .ld_i    (frame_load_i),
        .ld_ok_i (ld_ok),
        .frame_i (frame_i),
        .clr_i   (clr),
        .rec_o   (rec)
    );

    assign bus_req_o   = active;
    assign bus_addr_o  = cur.addr;
    assign bus_fc_o    = cur.fc;
    assign bus_wr_o    = cur.wr;
    assign bus_size_o  = cur.size;
    assign bus_wdata_o = cur.wdata;
    assign frame_o     = rec_to_frame(rec);

    // R3: a fault pulse always comes with a valid record on the frame
    p_fault_valid_r3: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> frame_o[FRAME_W-1]);

    // R6: a done pulse always comes with the record retired and busy down
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        replay_done_o |-> (!frame_o[FRAME_W-1] && !core_busy_o && !bus_req_o));
endmodule

// File: tb/bus_fault_replay_tb_top.sv
module bus_fault_replay_tb_top;
    import bfr_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               core_req_i = 1'b0;
    logic [31:0]        core_addr_i = '0;
    logic [2:0]         core_fc_i = '0;
    logic               core_wr_i = 1'b0;
    logic [1:0]         core_size_i = '0;
    logic [31:0]        core_wdata_i = '0;
    logic [31:0]        core_pc_i = '0;
    logic [15:0]        core_sr_i = '0;
    logic               core_busy_o, core_ack_o;
    logic [31:0]        core_rdata_o;
    logic               bus_req_o;
    logic [31:0]        bus_addr_o;
    logic [2:0]         bus_fc_o;
    logic               bus_wr_o;
    logic [1:0]         bus_size_o;
    logic [31:0]        bus_wdata_o;
    logic               bus_ack_i = 1'b0;
    logic               bus_err_i = 1'b0;
    logic [31:0]        bus_rdata_i = '0;
    logic               rte_i = 1'b0;
    logic               frame_load_i = 1'b0;
    logic [118:0]       frame_i = '0;
    logic [118:0]       frame_o;
    logic               fault_o, replay_done_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // model of the record and the open cycle
    logic        m_valid = 1'b0;
    logic [31:0] m_pc = '0;
    logic [15:0] m_sr = '0;
    logic [69:0] m_cyc = '0;
    logic [69:0] cur_exp = '0;

    always #2 clk = ~clk;

    bus_fault_replay dut_i (.*);

    function automatic logic [69:0] cyc_of(logic [31:0] a, logic [2:0] fc, logic wr,
                                           logic [1:0] sz, logic [31:0] wd);
        return {a, fc, wr, sz, wd};
    endfunction

    function automatic logic [118:0] frame_of(logic v, logic [31:0] pc, logic [15:0] sr,
                                              logic [69:0] c);
        return {v, pc, sr, c};
    endfunction

    function automatic logic [69:0] bus_view();
        return {bus_addr_o, bus_fc_o, bus_wr_o, bus_size_o, bus_wdata_o};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_ctx();
        core_pc_i = $urandom;
        core_sr_i = 16'($urandom);
    endtask

    task automatic start_core(input logic [69:0] c);
        @(negedge clk);
        {core_addr_i, core_fc_i, core_wr_i, core_size_i, core_wdata_i} = c;
        core_req_i = 1'b1;
        @(negedge clk);
        core_req_i = 1'b0;
        cur_exp = c;
        chk("R2 bus_req after request", 128'(bus_req_o), 128'(1));
        chk("R2 bus fields", 128'(bus_view()), 128'(c));
    endtask

    task automatic start_replay();
        @(negedge clk);
        rte_i = 1'b1;
        @(negedge clk);
        rte_i = 1'b0;
        cur_exp = m_cyc;
        chk("R6 busy on replay", 128'(core_busy_o), 128'(1));
        chk("R6 bus_req on replay", 128'(bus_req_o), 128'(1));
        chk("R6 replay fields", 128'(bus_view()), 128'(m_cyc));
    endtask

    // end the open cycle; called at a negedge while the cycle is active
    task automatic finish(input bit err, input int waits, input bit rpl, input string tag);
        logic [31:0] rd;
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk({tag, " R2 held"}, 128'({bus_req_o, bus_view()}), 128'({1'b1, cur_exp}));
        end
        rd = $urandom;
        bus_rdata_i = rd;
        if (err) begin
            bus_err_i = 1'b1;
            bus_ack_i = ($urandom % 2) == 1;
        end else begin
            bus_ack_i = 1'b1;
        end
        @(negedge clk);
        bus_err_i = 1'b0;
        bus_ack_i = 1'b0;
        chk({tag, " R3 bus_req drop"}, 128'(bus_req_o), 128'(0));
        if (err) begin
            m_valid = 1'b1;
            m_pc = core_pc_i;
            m_sr = core_sr_i;
            m_cyc = cur_exp;
            chk({tag, " R3 fault pulse"}, 128'({fault_o, core_ack_o, replay_done_o}), 128'(3'b100));
            chk({tag, " R4 frame"}, 128'(frame_o), 128'(frame_of(m_valid, m_pc, m_sr, m_cyc)));
            chk({tag, " R8 busy after fault"}, 128'(core_busy_o), 128'(0));
        end else begin
            if (rpl) m_valid = 1'b0;
            chk({tag, " R2 ack pulse"}, 128'({core_ack_o, fault_o, replay_done_o}),
                128'({1'b1, 1'b0, rpl}));
            chk({tag, " R2 rdata"}, 128'(core_rdata_o), 128'(rd));
            chk({tag, " R6 frame"}, 128'(frame_o), 128'(frame_of(m_valid, m_pc, m_sr, m_cyc)));
            chk({tag, " R6 busy"}, 128'(core_busy_o), 128'(0));
        end
        @(negedge clk);
        chk({tag, " R2 pulses end"}, 128'({core_ack_o, fault_o, replay_done_o}), 128'(0));
    endtask

    task automatic load_frame(input logic [118:0] f);
        @(negedge clk);
        frame_i = f;
        frame_load_i = 1'b1;
        @(negedge clk);
        frame_load_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [118:0] saved, junk;
        logic [69:0]  c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset outputs", 128'({bus_req_o, core_busy_o, core_ack_o, fault_o, replay_done_o}), 128'(0));
        chk("R1 reset frame", 128'(frame_o), 128'(0));

        // R7: rte with an empty record
        @(negedge clk);
        rte_i = 1'b1;
        @(negedge clk);
        rte_i = 1'b0;
        chk("R7 ignored rte", 128'({bus_req_o, core_busy_o}), 128'(0));

        // R2: read with wait states
        set_ctx();
        start_core(cyc_of(32'h0000_1000, 3'd1, 1'b0, 2'd1, 32'h0));
        finish(1'b0, 2, 1'b0, "read");

        // R3: write aborted
        set_ctx();
        start_core(cyc_of(32'h0040_2004, 3'd5, 1'b1, 2'd2, 32'hCAFE_F00D));
        finish(1'b1, 1, 1'b0, "write-fault");

        // R5: save, overwrite, restore
        saved = frame_o;
        junk = frame_of(1'b1, 32'h1111_2222, 16'h3333, cyc_of(32'h4444_5555, 3'd6, 1'b0, 2'd3, 32'h6666_7777));
        load_frame(junk);
        chk("R5 frame load", 128'(frame_o), 128'(junk));
        load_frame(saved);
        chk("R5 frame restore", 128'(frame_o), 128'(saved));

        // R9 / R5: collisions during a replay
        start_replay();
        @(negedge clk);
        core_req_i = 1'b1;
        core_addr_i = 32'hDEAD_0000;
        frame_i = junk;
        frame_load_i = 1'b1;
        @(negedge clk);
        core_req_i = 1'b0;
        frame_load_i = 1'b0;
        chk("R9 fields kept", 128'(bus_view()), 128'(m_cyc));
        chk("R5 load ignored", 128'(frame_o), 128'(saved));
        finish(1'b0, 0, 1'b1, "replay-ok");
        chk("R9 no late cycle", 128'(bus_req_o), 128'(0));

        // R8: replay faults again
        set_ctx();
        start_core(cyc_of(32'h0000_8000, 3'd2, 1'b0, 2'd1, 32'h0));
        finish(1'b1, 0, 1'b0, "fault-a");
        set_ctx();
        start_replay();
        finish(1'b1, 1, 1'b1, "R8 replay-fault");
        start_replay();
        finish(1'b0, 0, 1'b1, "R8 replay-ok");

        // R11: fetch, read, write chain
        set_ctx();
        start_core(cyc_of(32'h0001_0000, 3'd6, 1'b0, 2'd1, 32'h0));
        finish(1'b1, 0, 1'b0, "R11 fetch");
        start_replay();
        finish(1'b0, 1, 1'b1, "R11 fetch replay");
        set_ctx();
        start_core(cyc_of(32'h0002_0010, 3'd5, 1'b0, 2'd2, 32'h0));
        finish(1'b1, 0, 1'b0, "R11 read");
        start_replay();
        finish(1'b0, 0, 1'b1, "R11 read replay");
        set_ctx();
        start_core(cyc_of(32'h0003_0020, 3'd5, 1'b1, 2'd0, 32'h0000_00A5));
        finish(1'b1, 2, 1'b0, "R11 write");
        start_replay();
        chk("R11 write data replayed", 128'(bus_wdata_o), 128'(32'h0000_00A5));
        finish(1'b0, 0, 1'b1, "R11 write replay");

        // R10: rte and core request together
        set_ctx();
        start_core(cyc_of(32'h0005_0000, 3'd1, 1'b1, 2'd1, 32'h1234_5678));
        finish(1'b1, 0, 1'b0, "prep-r10");
        @(negedge clk);
        rte_i = 1'b1;
        core_req_i = 1'b1;
        core_addr_i = 32'hBAD0_BAD0;
        @(negedge clk);
        rte_i = 1'b0;
        core_req_i = 1'b0;
        cur_exp = m_cyc;
        chk("R10 replay wins", 128'({core_busy_o, bus_view()}), 128'({1'b1, m_cyc}));
        finish(1'b0, 0, 1'b1, "R10 replay");
        chk("R10 request dropped", 128'(bus_req_o), 128'(0));

        // R12: rte during a core cycle
        set_ctx();
        start_core(cyc_of(32'h0006_0000, 3'd2, 1'b0, 2'd1, 32'h0));
        finish(1'b1, 0, 1'b0, "prep-r12");
        start_core(cyc_of(32'h0007_0000, 3'd1, 1'b0, 2'd2, 32'h0));
        rte_i = 1'b1;
        @(negedge clk);
        rte_i = 1'b0;
        chk("R12 busy pending", 128'(core_busy_o), 128'(1));
        bus_ack_i = 1'b1;
        @(negedge clk);
        bus_ack_i = 1'b0;
        chk("R12 core cycle acked", 128'({core_ack_o, bus_req_o, core_busy_o}), 128'(3'b101));
        @(negedge clk);
        cur_exp = m_cyc;
        chk("R12 replay started", 128'({bus_req_o, bus_view()}), 128'({1'b1, m_cyc}));
        finish(1'b0, 0, 1'b1, "R12 replay");

        // random mix
        for (int it = 0; it < 60; it++) begin
            bit e;
            e = ($urandom % 10) < 4;
            if (m_valid && ($urandom % 2) == 1) begin
                if (($urandom % 3) == 0) begin
                    saved = frame_o;
                    load_frame(frame_of(1'b1, $urandom, 16'($urandom), 70'($urandom)));
                    load_frame(saved);
                    chk("R5 random restore", 128'(frame_o), 128'(saved));
                end
                set_ctx();
                start_replay();
                finish(e, $urandom % 3, 1'b1, "R6 random replay");
            end else begin
                set_ctx();
                c = cyc_of($urandom, 3'($urandom), 1'($urandom), 2'($urandom), $urandom);
                start_core(c);
                finish(e, $urandom % 3, 1'b0, "R2 random cycle");
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule